// File: doc/BRIEF.md
# Biphase-Mark Subframe Transmitter

This block turns a stream of stereo audio samples into a single self-clocking serial line for a consumer digital audio link. At the start of every frame it captures one left and one right 24-bit sample together with a validity flag and a short-word flag. It then emits two 32-slot subframes, left first. Each subframe opens with a synchronisation preamble, carries the sample, a validity bit, a user bit, one channel status bit and an even parity bit, and is coded with biphase-mark so that every bit cell starts with a transition.

The caller supplies a one-cycle `state_tick` strobe at the half-bit state rate, which is 128 strobes per sample period. Each strobe moves the line on by one state. Frames are counted modulo 192 to form a block. The 42 stored channel status bits are sent one per frame, in both subframes, and frames 42 and later send 0. In consumer mode the audio channel field of the channel status, bits 20 to 23, is generated from a stereo control input. Three control inputs can hold the line low: transmit enable, power and timing run. Dropping power or timing run also restarts the frame and block counters.

Top module: `bmc_subframe_tx`

## Requirements
- R1: Each frame takes exactly 128 accepted ticks: states 0–63 form subframe 1 (left) and states 64–127 form subframe 2 (right). `sample_take` is high in a cycle where `state_tick` is high only when that tick emits state 0 of a frame, and the samples, `short_word` and `validity` are captured on that edge.
- R2: Slots 0–3 (states 0–7 of a subframe) carry a preamble, emitted first state first, that does not follow the biphase rule. Subframe 1 of frame 0 uses 11101000, subframe 1 of every other frame uses 11100010, and every subframe 2 uses 11100100. These patterns apply when the preceding line state is 0; when it is 1 each pattern is inverted.
- R3: In slots 4–31 every bit cell starts by inverting the preceding state. A 1 inverts again at mid-cell and a 0 keeps the level.
- R4: Slots 4–27 carry the captured sample, bit 0 in slot 4 and the MSB in slot 27. When `short_word` was 1 at capture, slots 4–11 are sent as 0.
- R5: Slot 28 carries the captured validity flag (1 means unreliable), and slot 29, the user bit, is always 0.
- R6: Slot 30 of both subframes of frame n carries `chan_status[n]` for n below 42 and 0 for frames 42 to 191. The frame counter wraps from 191 to 0.
- R7: When `chan_status[0]` is 0, slot 30 in frames 20–23 is replaced. With `stereo` at 1 it is 1 in frame 20 only in subframe 1 and in frame 21 only in subframe 2, and 0 elsewhere in those frames. With `stereo` at 0 it is 0 in all four frames.
- R8: Slot 31 makes slots 4–31 of each subframe hold an even number of ones.
- R9: While `tx_en` is 0, `line_out` is 0 from the next clock. Framing keeps advancing, so the first frame after re-enable carries the next frame index.
- R10: While `pwr_on` or `timing_run` is 0 (or during reset), `line_out` is 0 from the next clock. The state and frame counters return to 0 and the internal line level returns to 0, so the first frame afterwards is frame 0 with its preamble referenced to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_tick | input | 1 | One-cycle strobe, one per half-bit state |
| left_sample | input | 24 | Channel 1 sample, two's complement |
| right_sample | input | 24 | Channel 2 sample, two's complement |
| short_word | input | 1 | 1: 16-bit samples, low 8 slots zeroed |
| validity | input | 1 | Validity flag for the frame (1 = unreliable) |
| chan_status | input | 42 | Stored channel status bits, bit n sent in frame n |
| stereo | input | 1 | Stereo control for the channel status channel field |
| tx_en | input | 1 | Transmit enable; 0 holds the line low |
| pwr_on | input | 1 | Power bit; 0 holds the line low and clears timing |
| timing_run | input | 1 | Timing run bit; 0 holds the line low and clears timing |
| line_out | output | 1 | Biphase-mark encoded serial line |
| sample_take | output | 1 | High on the tick that captures a new sample pair |

## Verification
Two functions collide on the first tick of frame 20: the preamble choice and the stereo override of channel status. The same happens on the last tick of frame 191, where the block counter wraps and the next preamble must switch to the block-start pattern. The bench sends a full block plus one frame and decodes every state of the line. It checks the preamble pattern, the channel status bit and the parity of each subframe against values it computes for the frame index, so a wrong wrap or a wrong override shows up in the same frame as a parity or pattern error. A second collision comes from dropping the power bit in the middle of a subframe. The bench checks that the line goes low at once and that the next frame restarts with the block-start preamble.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int SLOTS_PER_SUB = 32;
  localparam int AUDIO_BITS    = 24;
  localparam int PAYLOAD_BITS  = SLOTS_PER_SUB - 4;
  localparam int CH_FIELD_LO   = 20;
  localparam int CH_FIELD_HI   = 23;

  typedef enum logic [1:0] {PRE_BLOCK, PRE_CH1, PRE_CH2} pre_kind_e;

  function automatic logic [7:0] pre_pattern(input pre_kind_e kind);
    case (kind)
      PRE_BLOCK: pre_pattern = 8'b1110_1000;
      PRE_CH1:   pre_pattern = 8'b1110_0010;
      default:   pre_pattern = 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmc_timebase.sv
module bmc_timebase #(
  parameter int STATES = 128,
  parameter int FRAMES = 192,
  localparam int POS_W = $clog2(STATES),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clear,
  output logic [POS_W-1:0] pos_q,
  output logic [FRM_W-1:0] frame_q
);
  logic [POS_W-1:0] pos_d;
  logic [FRM_W-1:0] frame_d;

  always_comb begin
    pos_d   = pos_q;
    frame_d = frame_q;
    if (clear) begin
      pos_d   = '0;
      frame_d = '0;
    end else if (adv) begin
      if (pos_q == POS_W'(STATES - 1)) begin
        pos_d   = '0;
        frame_d = (frame_q == FRM_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else begin
      pos_q   <= pos_d;
      frame_q <= frame_d;
    end
  end
endmodule

// File: rtl/bmc_slot_bits.sv
module bmc_slot_bits
  import bmc_pkg::*;
#(
  parameter int FRAMES     = 192,
  parameter int CS_BITS    = 42,
  parameter int SHORT_ZERO = 8,
  localparam int FRM_W     = $clog2(FRAMES),
  localparam int CS_IDX_W  = $clog2(CS_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [AUDIO_BITS-1:0] left_in,
  input  logic [AUDIO_BITS-1:0] right_in,
  input  logic                  short_in,
  input  logic                  valid_in,
  input  logic [CS_BITS-1:0]    cs_bits,
  input  logic                  stereo,
  input  logic [FRM_W-1:0]      frame,
  input  logic                  chan,
  input  logic [4:0]            slot,
  output logic                  bit_val
);
  logic [AUDIO_BITS-1:0] left_q, right_q;
  logic                  short_q, valid_q;
  logic [AUDIO_BITS-1:0] audio;
  logic                  cs_raw, cs_bit, in_field;
  logic [PAYLOAD_BITS-2:0] body;
  logic [PAYLOAD_BITS-1:0] word;
  logic [4:0]              idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      short_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (take) begin
      left_q  <= left_in;
      right_q <= right_in;
      short_q <= short_in;
      valid_q <= valid_in;
    end
  end

  always_comb begin
    audio = chan ? right_q : left_q;
    if (short_q) audio[SHORT_ZERO-1:0] = '0;
  end

  always_comb begin
    cs_raw   = (frame < FRM_W'(CS_BITS)) ? cs_bits[frame[CS_IDX_W-1:0]] : 1'b0;
    in_field = (frame >= FRM_W'(CH_FIELD_LO)) && (frame <= FRM_W'(CH_FIELD_HI));
    if (!cs_bits[0] && in_field)
      cs_bit = stereo && ((!chan && frame == FRM_W'(CH_FIELD_LO)) ||
                          ( chan && frame == FRM_W'(CH_FIELD_LO + 1)));
    else
      cs_bit = cs_raw;
  end

  assign body = {cs_bit, 1'b0, valid_q, audio};
  assign word = {^body, body};
  assign idx  = slot - 5'd4;

  always_comb begin
    bit_val = 1'b0;
    if (slot >= 5'd4) bit_val = word[idx];
  end
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int STATES = 128,
  localparam int POS_W = $clog2(STATES),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clear,
  input  logic             gate,
  input  logic [POS_W-1:0] pos,
  input  logic [FRM_W-1:0] frame,
  input  logic             bit_val,
  output logic             line_q
);
  logic      lvl_q, lvl_d, pol_q, pol_d, ref_lvl, in_pre;
  logic [2:0] k;
  pre_kind_e kind;
  logic [7:0] pat;

  assign in_pre = (pos[5:3] == 3'd0);
  assign k      = pos[2:0];
  assign kind   = pos[6] ? PRE_CH2 : ((frame == '0) ? PRE_BLOCK : PRE_CH1);
  assign pat    = pre_pattern(kind);
  assign ref_lvl = (k == 3'd0) ? lvl_q : pol_q;

  always_comb begin
    lvl_d = lvl_q;
    pol_d = pol_q;
    if (clear) begin
      lvl_d = 1'b0;
      pol_d = 1'b0;
    end else if (adv) begin
      if (in_pre) begin
        lvl_d = pat[3'd7 - k] ^ ref_lvl;
        if (k == 3'd0) pol_d = lvl_q;
      end else if (!pos[0]) begin
        lvl_d = ~lvl_q;
      end else begin
        lvl_d = bit_val ? ~lvl_q : lvl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pol_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      pol_q  <= pol_d;
      line_q <= gate & lvl_d;
    end
  end
endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
  import bmc_pkg::*;
#(
  parameter int FRAMES     = 192,
  parameter int CS_BITS    = 42,
  parameter int SHORT_ZERO = 8,
  localparam int STATES    = 4 * SLOTS_PER_SUB,
  localparam int POS_W     = $clog2(STATES),
  localparam int FRM_W     = $clog2(FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  state_tick,
  input  logic [AUDIO_BITS-1:0] left_sample,
  input  logic [AUDIO_BITS-1:0] right_sample,
  input  logic                  short_word,
  input  logic                  validity,
  input  logic [CS_BITS-1:0]    chan_status,
  input  logic                  stereo,
  input  logic                  tx_en,
  input  logic                  pwr_on,
  input  logic                  timing_run,
  output logic                  line_out,
  output logic                  sample_take
);
  logic             run, gate, adv, clear, bit_val;
  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frame_q;

  assign run   = pwr_on & timing_run;
  assign gate  = run & tx_en;
  assign adv   = state_tick & run;
  assign clear = ~run;
  assign sample_take = adv & (pos_q == '0);

  bmc_timebase #(.STATES(STATES), .FRAMES(FRAMES)) u_time (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clear(clear),
    .pos_q(pos_q), .frame_q(frame_q)
  );

  bmc_slot_bits #(.FRAMES(FRAMES), .CS_BITS(CS_BITS), .SHORT_ZERO(SHORT_ZERO)) u_bits (
    .clk(clk), .rst_n(rst_n), .take(sample_take),
    .left_in(left_sample), .right_in(right_sample),
    .short_in(short_word), .valid_in(validity),
    .cs_bits(chan_status), .stereo(stereo),
    .frame(frame_q), .chan(pos_q[6]), .slot(pos_q[5:1]),
    .bit_val(bit_val)
  );

  bmc_line_encoder #(.FRAMES(FRAMES), .STATES(STATES)) u_enc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clear(clear), .gate(gate),
    .pos(pos_q), .frame(frame_q), .bit_val(bit_val), .line_q(line_out)
  );
endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker #(
  parameter int STATES = 128,
  parameter int FRAMES = 192,
  localparam int POS_W = $clog2(STATES),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             state_tick,
  input logic             tx_en,
  input logic             pwr_on,
  input logic             timing_run,
  input logic             line_out,
  input logic [POS_W-1:0] pos,
  input logic [FRM_W-1:0] frame
);
  logic gate;
  assign gate = tx_en & pwr_on & timing_run;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pos) < STATES) && (32'(frame) < FRAMES)); // R1

  AST_PRE_SECOND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_tick && gate && $past(gate) && pos[5:0] == 6'd1)
    |=> (line_out == $past(line_out))); // R2

  AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_tick && gate && $past(gate) && !pos[0] &&
     (pos[5:3] != 3'd0 || pos[2:0] == 3'd0))
    |=> (line_out != $past(line_out))); // R3

  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !line_out); // R9

  AST_TIMING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_on && timing_run) |=> (pos == '0 && frame == '0)); // R10
endmodule

bind bmc_subframe_tx bmc_tx_checker #(.STATES(STATES), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_tick(state_tick), .tx_en(tx_en),
  .pwr_on(pwr_on), .timing_run(timing_run), .line_out(line_out),
  .pos(pos_q), .frame(frame_q)
);

// File: tb/sim_bmc_subframe_tx.sv
`timescale 1ns/1ps
module sim_bmc_subframe_tx;
  logic clk = 1'b0;
  logic rst_n;
  logic state_tick;
  logic [23:0] left_sample, right_sample;
  logic short_word, validity, stereo, tx_en, pwr_on, timing_run;
  logic [41:0] chan_status;
  logic line_out, sample_take;

  int n_chk = 0;
  int n_fail = 0;
  int fnum = 0;
  logic prev_lvl = 1'b0;
  logic [127:0] st;

  always #2.5 clk = ~clk;

  bmc_subframe_tx u0 (
    .clk(clk), .rst_n(rst_n), .state_tick(state_tick),
    .left_sample(left_sample), .right_sample(right_sample),
    .short_word(short_word), .validity(validity), .chan_status(chan_status),
    .stereo(stereo), .tx_en(tx_en), .pwr_on(pwr_on), .timing_run(timing_run),
    .line_out(line_out), .sample_take(sample_take)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (frame %0d)", req, act, exp, fnum);
    end
  endtask

  task automatic do_tick(output logic tk, output logic lv);
    @(negedge clk); state_tick = 1'b1;
    #1 tk = sample_take;
    @(negedge clk); state_tick = 1'b0;
    lv = line_out;
  endtask

  function automatic logic [7:0] exp_pre(input int f, input int c);
    if (c == 1) return 8'b11100100;
    if (f == 0) return 8'b11101000;
    return 8'b11100010;
  endfunction

  function automatic logic exp_cs(input int f, input int c);
    if (!chan_status[0] && f >= 20 && f <= 23)
      return stereo && ((c == 0 && f == 20) || (c == 1 && f == 21));
    return (f < 42) ? chan_status[f] : 1'b0;
  endfunction

  // capture one frame of 128 states into st; checks the capture strobe (R1)
  task automatic grab_frame(input logic [23:0] l, input logic [23:0] r,
                            input logic sw, input logic v);
    int takes = 0;
    logic tk, lv;
    left_sample = l; right_sample = r; short_word = sw; validity = v;
    for (int i = 0; i < 128; i++) begin
      do_tick(tk, lv);
      st[i] = lv;
      if (tk) takes += (i == 0) ? 1 : 100;
    end
    chk("R1 sample_take only on state 0", takes, 1);
  endtask

  // decode and check a captured frame against the requirements
  task automatic check_frame(input logic [23:0] l, input logic [23:0] r,
                             input logic sw, input logic v);
    for (int c = 0; c < 2; c++) begin
      logic [7:0] pre;
      logic [31:0] b;
      logic p, ref_lvl;
      int bad = 0;
      logic [23:0] smp;
      logic [23:0] got;
      ref_lvl = (c == 0) ? prev_lvl : st[63];
      for (int k = 0; k < 8; k++) pre[7-k] = st[c*64+k];
      chk("R2 preamble", pre, exp_pre(fnum, c) ^ {8{ref_lvl}});
      b = '0;
      for (int s = 4; s < 32; s++) begin
        p = st[c*64 + 2*s - 1];
        if (st[c*64 + 2*s] == p) bad++;
        b[s] = st[c*64 + 2*s] ^ st[c*64 + 2*s + 1];
      end
      chk("R3 cell start edges", bad, 0);
      smp = (c == 0) ? l : r;
      if (sw) smp[7:0] = 8'h00;
      got = b[27:4];
      chk("R4 audio slots", got, smp);
      chk("R5 validity slot", b[28], v);
      chk("R5 user slot zero", b[29], 1'b0);
      if (!chan_status[0] && fnum >= 20 && fnum <= 23)
        chk("R7 channel field", b[30], exp_cs(fnum, c));
      else
        chk("R6 status slot", b[30], exp_cs(fnum, c));
      chk("R8 even parity", ^b[31:4], 1'b0);
    end
    prev_lvl = st[127];
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                            input logic sw, input logic v);
    grab_frame(l, r, sw, v);
    check_frame(l, r, sw, v);
    fnum = (fnum + 1) % 192;
  endtask

  task automatic timing_restart();
    @(negedge clk); timing_run = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 line low while timing stopped", line_out, 1'b0);
    timing_run = 1'b1;
    fnum = 0; prev_lvl = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; state_tick = 1'b0;
    left_sample = '0; right_sample = '0; short_word = 1'b0; validity = 1'b0;
    chan_status = 42'h000_0000_0004; stereo = 1'b0;
    tx_en = 1'b1; pwr_on = 1'b1; timing_run = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 line low in reset", line_out, 1'b0);
    chk("R1 no take in reset", sample_take, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 line low after reset", line_out, 1'b0);
  endtask

  // full block plus one frame: status walk, wrap, stereo field, data patterns
  task automatic t_full_block();
    chan_status = 42'h2AB_CDEF_1236;
    stereo = 1'b1;
    for (int f = 0; f < 193; f++)
      send_frame(24'hA5A5A5 ^ 24'(f * 32'h1357), 24'h5A0F3C ^ 24'(f * 32'h0BEEF),
                 (f % 5) == 3, (f % 7) == 2);
  endtask

  task automatic t_mono_field();
    timing_restart();
    stereo = 1'b0;
    chan_status = 42'h3FF_FFFF_FFFE;
    for (int f = 0; f < 24; f++)
      send_frame(24'hFFFFFF, 24'h000001, f[0], 1'b0);
  endtask

  task automatic t_pro_field();
    timing_restart();
    stereo = 1'b1;
    chan_status = 42'h155_5555_5B51;
    for (int f = 0; f < 24; f++)
      send_frame(24'h800000, 24'h7FFFFF, 1'b0, 1'b1);
  endtask

  task automatic t_tx_disable();
    logic tk, lv;
    int highs = 0, takes = 0;
    send_frame(24'h123456, 24'h654321, 1'b0, 1'b0);
    @(negedge clk); tx_en = 1'b0;
    for (int i = 0; i < 128; i++) begin
      do_tick(tk, lv);
      if (lv) highs++;
      if (tk) takes++;
    end
    chk("R9 line low while disabled", highs, 0);
    chk("R9 framing continues while disabled", takes, 1);
    fnum = (fnum + 1) % 192;
    tx_en = 1'b1;
    prev_lvl = 1'b0;
    send_frame(24'h0F0F0F, 24'hF0F0F0, 1'b0, 1'b0);
  endtask

  task automatic t_power_mid_frame();
    logic tk, lv;
    send_frame(24'h111111, 24'h222222, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) do_tick(tk, lv);
    @(negedge clk); pwr_on = 1'b0;
    @(negedge clk);
    chk("R10 line low after power bit cleared", line_out, 1'b0);
    @(negedge clk); pwr_on = 1'b1;
    fnum = 0; prev_lvl = 1'b0;
    send_frame(24'hC0FFEE, 24'hBADCAF, 1'b0, 1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_full_block();
    t_mono_field();
    t_pro_field();
    t_tx_disable();
    t_power_mid_frame();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 180000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule